// File: doc/BRIEF.md
# Split-Input Odd-Multiple Lookup Constant Multiplier

This block multiplies an 8-bit unsigned operand by a fixed coefficient that is set at build time. It does not store all 256 products. It breaks the operand into two 4-bit halves and looks up each half separately. A single 8-entry table holds only the odd multiples of the coefficient, 1·A, 3·A and so on up to 15·A. The table has two read ports, one for each half.

For each half, a small encoder does three things:
- It finds how many trailing zero bits the nibble has.
- It maps the remaining odd part of the nibble to a table address.
- It raises a zero flag when the nibble is all zeros.

The table keeps its words bit-inverted. An inverting zero-force stage turns the selected word back to true form, or drives zero when the zero flag is set. A two-stage logarithmic shifter then restores the even factor by shifting left 0 to 3 places.

The upper partial product is weighted by 16 and added to the lower one. An optional register stage can sit between the lookup and the add. A valid flag travels with the data so that it has the same latency, which is 1 + PIPE cycles from an accepted operand to the product.

There is no control state machine. The datapath is a fixed pipeline, and the only sequencing is the valid flag moving through it.

Top module: `lutmul_top`

## Requirements
- R1: When `in_valid` is high in cycle n, `out_prod` equals COEF × `in_x`, as an unsigned (W+8)-bit value, in cycle n + 1 + PIPE.
- R2: `out_valid` is high exactly in the cycles that are 1 + PIPE cycles after a cycle with `in_valid` high. While `rst_n` is low, `out_valid` and `out_prod` are 0.
- R3: The result never overflows. For `in_x` = 255 the output is exactly COEF × 255, and no output ever exceeds that value.
- R4: A zero operand gives a zero product. When only one nibble is zero, that nibble contributes nothing.
- R5: The high nibble carries weight 16. An operand whose low nibble is 0 gives COEF × (high nibble) × 16.
- R6: In cycles where `out_valid` is low, `out_prod` keeps its last value. An `in_x` presented while `in_valid` is low has no effect on it.
- R7: The product is correct for coefficient 0, where every output is 0, and for coefficient 2^W−1, across all 256 operands.
- R8: Nibbles that are powers of two (1, 2, 4, 8) need the full 0–3 shift range, and they still give exact products.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present this cycle |
| in_x | input | 8 | Unsigned operand |
| out_valid | output | 1 | Product present this cycle |
| out_prod | output | W+8 | Unsigned product COEF × operand |

## Verification
The hardest case to reach from the ports is the hold behaviour of the result register. It must keep its value during idle gaps while `in_x` carries unrelated data, and it must then pick up the next valid operand straight away. The stimulus mixes back-to-back runs with idle gaps of varying length. During every gap it drives a fixed non-zero pattern on `in_x`.

Three instances share the same inputs: a mid-range coefficient, zero, and the all-ones coefficient. This puts the edge coefficients through the full 256-value sweep. The sweep reaches every shift amount and every zero-flag combination of both nibbles.

// File: rtl/lutmul_pkg.sv
package lutmul_pkg;

    // Per-nibble lookup control produced by the encoder.
    typedef struct packed {
        logic       zero;   // nibble is all zeros
        logic [1:0] shamt;  // trailing-zero count, 0..3
        logic [2:0] addr;   // index of odd multiple (odd-1)/2
    } nib_ctl_t;

    localparam int NIB_W  = 4;
    localparam int N_NIBS = 2;
    localparam int N_ODD  = 8;

endpackage

// File: rtl/lutmul_nib_enc.sv
module lutmul_nib_enc
    import lutmul_pkg::*;
(
    input  logic [NIB_W-1:0] nib,
    output nib_ctl_t         ctl
);

    always_comb begin
        ctl.zero = (nib == '0);
        if (nib[0])      ctl.shamt = 2'd0;
        else if (nib[1]) ctl.shamt = 2'd1;
        else if (nib[2]) ctl.shamt = 2'd2;
        else             ctl.shamt = 2'd3;
        unique case (ctl.shamt)
            2'd0: ctl.addr = nib[3:1];
            2'd1: ctl.addr = {1'b0, nib[3:2]};
            2'd2: ctl.addr = {2'b00, nib[3]};
            2'd3: ctl.addr = 3'd0;
        endcase
    end

endmodule

// File: rtl/lutmul_odd_rom.sv
module lutmul_odd_rom
    import lutmul_pkg::*;
#(
    parameter int           W     = 8,
    parameter logic [W-1:0] COEF  = '1,
    parameter int           PORTS = 2
) (
    input  logic [PORTS-1:0][2:0]   rd_addr,
    output logic [PORTS-1:0][W+3:0] rd_word_n
);

    localparam int WP = W + NIB_W;

    logic [WP-1:0] tbl_n [N_ODD];

    // Words are kept bit-inverted; the zero-force stage restores them.
    for (genvar i = 0; i < N_ODD; i++) begin : g_entry
        assign tbl_n[i] = ~(WP'(COEF) * WP'(2 * i + 1));
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        assign rd_word_n[p] = tbl_n[rd_addr[p]];
    end

endmodule

// File: rtl/lutmul_nib_path.sv
module lutmul_nib_path
    import lutmul_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W+3:0] word_n,
    input  nib_ctl_t     ctl,
    output logic [W+3:0] part
);

    localparam int WP     = W + NIB_W;
    localparam int STAGES = 2;

    logic [WP-1:0] stg [STAGES+1];

    // Inverting zero-force stage: zero flag wins, otherwise true-form word.
    assign stg[0] = ctl.zero ? '0 : ~word_n;

    // Logarithmic shifter: stage k shifts by 2**k.
    for (genvar k = 0; k < STAGES; k++) begin : g_shift
        assign stg[k+1] = ctl.shamt[k] ? (stg[k] << (1 << k)) : stg[k];
    end

    assign part = stg[STAGES];

endmodule

// File: rtl/lutmul_top.sv
module lutmul_top
    import lutmul_pkg::*;
#(
    parameter int           W    = 8,
    parameter logic [W-1:0] COEF = 8'd173,
    parameter int           PIPE = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [7:0]   in_x,
    output logic         out_valid,
    output logic [W+7:0] out_prod
);

    localparam int WP = W + NIB_W;
    localparam int WO = W + 8;

    nib_ctl_t                    ctl  [N_NIBS];
    logic [N_NIBS-1:0][2:0]      addr;
    logic [N_NIBS-1:0][WP-1:0]   word_n;
    logic [WP-1:0]               part [N_NIBS];

    for (genvar h = 0; h < N_NIBS; h++) begin : g_half
        lutmul_nib_enc u_enc (
            .nib (in_x[h*NIB_W +: NIB_W]),
            .ctl (ctl[h])
        );
        assign addr[h] = ctl[h].addr;
        lutmul_nib_path #(.W(W)) u_path (
            .word_n (word_n[h]),
            .ctl    (ctl[h]),
            .part   (part[h])
        );
    end

    lutmul_odd_rom #(.W(W), .COEF(COEF), .PORTS(N_NIBS)) u_rom (
        .rd_addr   (addr),
        .rd_word_n (word_n)
    );

    logic          st_v;
    logic [WP-1:0] st_lo, st_hi;

    if (PIPE != 0) begin : g_pipe
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_v  <= 1'b0;
                st_lo <= '0;
                st_hi <= '0;
            end else begin
                st_v <= in_valid;
                if (in_valid) begin
                    st_lo <= part[0];
                    st_hi <= part[1];
                end
            end
        end
    end else begin : g_nopipe
        assign st_v  = in_valid;
        assign st_lo = part[0];
        assign st_hi = part[1];
    end

    logic [WO-1:0] sum;
    assign sum = {st_hi, 4'b0000} + {4'b0000, st_lo};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_prod  <= '0;
        end else begin
            out_valid <= st_v;
            if (st_v) out_prod <= sum;
        end
    end

endmodule

// File: rtl/lutmul_chk.sv
module lutmul_chk #(
    parameter int           W    = 8,
    parameter logic [W-1:0] COEF = '1,
    parameter int           PIPE = 1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [7:0]   in_x,
    input logic         out_valid,
    input logic [W+7:0] out_prod
);

    localparam int LAT = 1 + PIPE;
    localparam int WO  = W + 8;
    localparam logic [WO-1:0] MAXP = WO'(COEF) * WO'(255);

    // Cycles since reset release, saturating at LAT.
    logic [2:0] warm;
    always_ff @(posedge clk) begin
        if (!rst_n)                warm <= '0;
        else if (warm < 3'(LAT))   warm <= warm + 3'd1;
    end
    logic ready;
    assign ready = (warm >= 3'(LAT));

    assert_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(in_valid, LAT)) |-> out_prod == WO'(COEF) * WO'($past(in_x, LAT)));

    assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(in_valid, LAT)) |-> out_valid);

    assert_valid_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !$past(in_valid, LAT)) |-> !out_valid);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_prod <= MAXP);

    assert_zero_operand_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(in_valid, LAT) && $past(in_x, LAT) == 8'd0) |-> out_prod == '0);

    assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_prod));

endmodule

bind lutmul_top lutmul_chk #(.W(W), .COEF(COEF), .PIPE(PIPE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_x      (in_x),
    .out_valid (out_valid),
    .out_prod  (out_prod)
);

// File: tb/sim_lutmul_top.sv
module sim_lutmul_top;

    localparam int W    = 8;
    localparam int PIPE = 1;
    localparam int WO   = W + 8;
    localparam logic [W-1:0] CA = 8'd173;
    localparam logic [W-1:0] CB = 8'd0;
    localparam logic [W-1:0] CC = 8'hFF;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 8 ns period

    logic          rst_n;
    logic          in_valid;
    logic [7:0]    in_x;
    logic          ov [3];
    logic [WO-1:0] op [3];
    logic [W-1:0]  coef [3];

    initial begin
        coef[0] = CA;
        coef[1] = CB;
        coef[2] = CC;
    end

    lutmul_top #(.W(W), .COEF(CA), .PIPE(PIPE)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x),
        .out_valid(ov[0]), .out_prod(op[0]));
    lutmul_top #(.W(W), .COEF(CB), .PIPE(PIPE)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x),
        .out_valid(ov[1]), .out_prod(op[1]));
    lutmul_top #(.W(W), .COEF(CC), .PIPE(PIPE)) u2 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x),
        .out_valid(ov[2]), .out_prod(op[2]));

    int         n_chk = 0;
    int         n_bad = 0;
    bit         done  = 1'b0;
    logic [7:0] expq [$];
    logic [WO-1:0] last [3];

    task automatic check(input string tag, input logic [WO-1:0] act, input logic [WO-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic send(input logic [7:0] x);
        @(negedge clk);
        in_valid = 1'b1;
        in_x     = x;
        expq.push_back(x);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_x     = 8'hA5;   // unrelated data on the operand while idle
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        logic [7:0] x;
        string      tag;
        if (rst_n) begin
            if (ov[0]) begin
                if (expq.size() == 0) begin
                    check("R2 unexpected out_valid", 1, 0);
                end else begin
                    x = expq.pop_front();
                    for (int i = 0; i < 3; i++) begin
                        if (i > 0)                    tag = "R7";
                        else if (x == 8'd0)           tag = "R4";
                        else if (x == 8'd255)         tag = "R3";
                        else if (x[3:0] == 4'd0)      tag = "R5";
                        else if ($countones(x[3:0]) <= 1 && $countones(x[7:4]) <= 1)
                                                      tag = "R8";
                        else                          tag = "R1";
                        check(tag, op[i], WO'(coef[i]) * WO'(x));
                        check("R2 valid alignment", WO'(ov[i]), WO'(1));
                        last[i] = op[i];
                    end
                end
            end else begin
                for (int i = 0; i < 3; i++) begin
                    check("R6 hold while idle", op[i], last[i]);
                    check("R2 valid low", WO'(ov[i]), WO'(0));
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired, run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] lfsr;
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_x     = 8'h00;
        for (int i = 0; i < 3; i++) last[i] = '0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            check("R2 reset out_valid", WO'(ov[i]), WO'(0));
            check("R2 reset out_prod", op[i], '0);
        end
        in_valid = 1'b1;   // held during reset: must not leak out
        in_x     = 8'h3C;
        @(negedge clk);
        in_valid = 1'b0;
        rst_n    = 1'b1;
        idle(3);

        // Full sweep back-to-back (R1, R3, R4, R5, R7, R8)
        for (int v = 0; v < 256; v++) send(8'(v));
        idle(4);

        // Boundary operands with gaps (R3, R4, R5, R8, R6)
        send(8'h00); idle(2);
        send(8'hFF); idle(1);
        send(8'h10); send(8'h20); send(8'h40); send(8'h80);
        idle(3);
        send(8'h01); send(8'h02); send(8'h04); send(8'h08);
        send(8'h88); send(8'h18); send(8'h81); idle(5);

        // Pseudo-random mix with irregular gaps (R1, R6)
        lfsr = 8'hB7;
        for (int k = 0; k < 200; k++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            send(lfsr);
            if (lfsr[1:0] == 2'b00) idle(int'(lfsr[4:2]) + 1);
        end
        idle(PIPE + 4);

        check("R2 all results delivered", WO'(expq.size()), WO'(0));
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule